// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is a synthesizable behavioural model of a synchronous SRAM with a short linear burst. At a rising clock edge a new external address is taken in when one of two active-low address strobes asks for it: a processor strobe (`adsp_n`) or a controller strobe (`adsc_n`). The same edge decides whether the device is selected at all, using three chip enables. The two lowest address bits then act as a 2-bit burst counter. Each edge with the advance input (`adv_n`) low moves the counter on by one inside an aligned 4-word block. The upper address bits do not change. Each word has two 9-bit byte lanes (8 data bits plus a parity bit). A lane can be written through a global write enable or through per-lane byte selects qualified by a byte-write enable.

Every selected clock edge without a write is a read. The word at the current address is registered and shows on `dq_out` after that edge. The data bus is split into an input, an output and an output-enable flag (`dq_oe`) that a pad ring or a test harness resolves into tri-state pins. The asynchronous, active-low `oe_n` gates `dq_oe` without a clock. After the device leaves the deselected state, the outputs stay off for the first clock whatever `oe_n` does. The interface carries one access per clock and has no valid/ready handshake and no back-pressure. The controller owns the timing completely, and every edge counts. The address width is a parameter, so the memory can be simulated at a small depth.

Top module: `bsram_top`

## Requirements
- R1: At a rising edge where the address is loaded (`adsc_n` low, or `adsp_n` low with `ce1_n` low), the device becomes active and the internal address takes `addr` if `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise it becomes deselected: it then neither reads nor writes, and after one further edge `dq_oe` is 0.
- R2: While `ce1_n` is 1, a low `adsp_n` has no effect. With `adsc_n` high, the address and the selected state keep their values, and the next read returns the previously addressed word.
- R3: `ce1_n`, `ce2` and `ce3_n` are looked at only at an edge that loads an address. Changing them during a burst neither deselects the device nor alters the burst.
- R4: At an edge with no load, the device active and `adv_n` low, address bits [1:0] increment modulo 4 and bits above them stay unchanged. A burst started at low bits k visits k, k+1, k+2, k+3 (mod 4).
- R5: With both strobes high and `adv_n` high, the address holds, and each further edge re-reads the same word.
- R6: At an active edge with `gw_n` low, both lanes of the word at the current address (the address held before that edge) take `dq_in`, whatever `bwe_n` and `bw_n` are.
- R7: With `gw_n` high and `bwe_n` low, lane i is written only if `bw_n[i]` is 0. Lane 0 is `dq[8:0]` and lane 1 is `dq[17:9]`. An unselected lane keeps its contents. With `bwe_n` high, no lane is written.
- R8: An active edge at which no lane is written registers the word at the current address. It appears on `dq_out`, with `dq_oe` high while `oe_n` is 0, after that edge.
- R9: `dq_oe` is 0 whenever `oe_n` is 1. The gate is combinational, with no clock.
- R10: After the edge that selects the device from the deselected state, `dq_oe` stays 0 for that clock even with `oe_n` low.
- R11: After reset the device is deselected and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane byte select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*9 | Write data |
| dq_out | output | LANES*9 | Read data |
| dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The clocked properties assume that every strobe, enable and write input is a known 0 or 1 at each rising edge once reset is released. The stimulus changes inputs only on the falling edge, so this holds. The burst property counts on no load at the edge it judges. The bench never pulses a strobe during the beats it is checking as a burst, and a load always comes in a cycle of its own, separate from write beats. The output-mask property relates `dq_oe` to the cycle in which the device turns active. The bench reaches that cycle only through a controller-strobe load after an explicit deselect.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANE_W = 9;

  function automatic logic chip_selected(input logic ce1_n, input logic ce2,
                                         input logic ce3_n);
    return !ce1_n && ce2 && !ce3_n;
  endfunction
endpackage

// File: rtl/bsram_addr_ctrl.sv
module bsram_addr_ctrl #(
  parameter int AW    = 8,
  parameter int CNT_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  output logic [AW-1:0] cur_addr,
  output logic          active
);
  import bsram_pkg::*;

  logic load;
  logic sel;

  always_comb begin
    load = (!adsp_n && !ce1_n) || !adsc_n;
    sel  = chip_selected(ce1_n, ce2, ce3_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      active   <= 1'b0;
    end else if (load) begin
      active   <= sel;
      cur_addr <= addr;
    end else if (!adv_n && active) begin
      cur_addr[CNT_W-1:0] <= CNT_W'(cur_addr[CNT_W-1:0] + 1'b1);
    end
  end
endmodule

// File: rtl/bsram_write_dec.sv
module bsram_write_dec #(
  parameter int LANES = 2
) (
  input  logic             active,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_en
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = active && (!gw_n || (!bwe_n && !bw_n[i]));
  end

  assign rd_en = active && (lane_we == '0);
endmodule

// File: rtl/bsram_mem_array.sv
module bsram_mem_array #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [AW-1:0]           cur_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[i]) store[cur_addr] <= wdata[i*LANE_W +: LANE_W];
      if (rd_en) rdata[i*LANE_W +: LANE_W] <= store[cur_addr];
    end
  end
endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic oe_n,
  output logic dq_oe
);
  logic data_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_ok <= 1'b0;
    else        data_ok <= rd_en;
  end

  assign dq_oe = data_ok && !oe_n;
endmodule

// File: rtl/bsram_top.sv
module bsram_top #(
  parameter int AW    = 8,
  parameter int LANES = 2,
  parameter int CNT_W = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [AW-1:0]                      addr,
  input  logic                               adsp_n,
  input  logic                               adsc_n,
  input  logic                               adv_n,
  input  logic                               ce1_n,
  input  logic                               ce2,
  input  logic                               ce3_n,
  input  logic                               gw_n,
  input  logic                               bwe_n,
  input  logic [LANES-1:0]                   bw_n,
  input  logic                               oe_n,
  input  logic [LANES*bsram_pkg::LANE_W-1:0] dq_in,
  output logic [LANES*bsram_pkg::LANE_W-1:0] dq_out,
  output logic                               dq_oe
);
  localparam int DW = LANES * bsram_pkg::LANE_W;

  logic [AW-1:0]    cur_addr;
  logic             active;
  logic [LANES-1:0] lane_we;
  logic             rd_en;
  logic [DW-1:0]    rdata;

  bsram_addr_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .cur_addr(cur_addr), .active(active)
  );

  bsram_write_dec #(.LANES(LANES)) u_wdec (
    .active(active), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lane_we(lane_we), .rd_en(rd_en)
  );

  bsram_mem_array #(.AW(AW), .LANES(LANES), .LANE_W(bsram_pkg::LANE_W)) u_mem (
    .clk(clk), .cur_addr(cur_addr), .lane_we(lane_we), .rd_en(rd_en),
    .wdata(dq_in), .rdata(rdata)
  );

  bsram_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .oe_n(oe_n), .dq_oe(dq_oe)
  );

  assign dq_out = rdata;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          adsp_n,
  input logic          adsc_n,
  input logic          adv_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          oe_n,
  input logic [AW-1:0] cur_addr,
  input logic          active,
  input logic          dq_oe
);
  a_r1_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && !ce1_n && ce2 && !ce3_n) |=> (active && cur_addr == $past(addr)));

  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && !(!ce1_n && ce2 && !ce3_n)) |=> !active);

  a_r2_adsp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && ce1_n && adsc_n && adv_n) |=> ($stable(cur_addr) && $stable(active)));

  a_r3_ce_unsampled: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && adsc_n) |=> $stable(active));

  a_r4_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && adsc_n && !adv_n && active) |=>
      (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1) &&
       cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && adsc_n && adv_n) |=> $stable(cur_addr));

  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r10_first_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !dq_oe);
endmodule

bind bsram_top bsram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
  .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n),
  .cur_addr(cur_addr), .active(active), .dq_oe(dq_oe)
);

// File: tb/bsram_top_tb.sv
module bsram_top_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
  logic [1:0] bw_n;
  logic [17:0] dq_in;
  logic [17:0] dq_out;
  logic dq_oe;

  logic [17:0] model [DEPTH];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bsram_top #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [17:0] pat(input int a, input int salt);
    return 18'((a * 37 + salt * 1013) ^ 18'h2A5A5);
  endfunction

  function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] a, input int k);
    return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
  endtask

  task automatic select_on();
    ce1_n = 0; ce2 = 1; ce3_n = 0;
  endtask

  task automatic load_c(input logic [AW-1:0] a);
    addr = a; adsc_n = 0; step(); adsc_n = 1;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [17:0] d);
    select_on(); load_c(a);
    gw_n = 0; dq_in = d; step(); gw_n = 1;
    model[a] = d;
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a);
    select_on(); load_c(a);
    step();
    chk(req, dq_out, model[a]);
    chk(req, 18'(dq_oe), 18'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); select_on(); oe_n = 0; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R11 reset oe", 18'(dq_oe), 18'd0);

    // R6 global write sweep over every address, then R8 read sweep
    for (int a = 0; a < DEPTH; a++) write_word(AW'(a), pat(a, 1));
    for (int a = 0; a < DEPTH; a++) read_check("R8 R1 sweep read", AW'(a));

    // R7 byte selects and R6 global write overriding byte selects
    for (int a = 0; a < 64; a++) begin
      logic [17:0] d;
      logic [1:0] sel;
      d = pat(a, 7);
      sel = 2'(a % 4);
      select_on(); load_c(AW'(a));
      dq_in = d; bw_n = sel;
      if ((a % 8) >= 4) begin
        gw_n = 0; bwe_n = 1'(a % 2);
        model[a] = d;
      end else begin
        bwe_n = (a >= 32) ? 1'b1 : 1'b0;
        if (!bwe_n) begin
          if (!sel[0]) model[a][8:0] = d[8:0];
          if (!sel[1]) model[a][17:9] = d[17:9];
        end
      end
      step(); idle();
    end
    for (int a = 0; a < 64; a++) read_check("R7 R6 lane result", AW'(a));

    // R4 burst write with wrap, then R4 burst read and R5 hold
    for (int s = 0; s < 8; s++) begin
      logic [AW-1:0] a;
      a = AW'(100 + s * 9);
      select_on(); load_c(a);
      for (int k = 0; k < 4; k++) begin
        gw_n = 0; adv_n = 0; dq_in = pat(s * 4 + k, 3);
        model[burst_addr(a, k)] = dq_in;
        step();
      end
      idle();
    end
    for (int s = 0; s < 16; s++) begin
      logic [AW-1:0] a;
      a = AW'(s < 8 ? 100 + s * 9 : s * 12 + s % 4);
      select_on(); load_c(a);
      for (int k = 0; k < 4; k++) begin
        adv_n = 0;
        if (k == 2 && s % 2 == 1) begin ce2 = 0; ce3_n = 1; end
        step();
        chk("R4 R3 burst beat", dq_out, model[burst_addr(a, k)]);
      end
      adv_n = 1;
      step();
      chk("R5 hold after wrap", dq_out, model[a]);
      step();
      chk("R5 repeat read", dq_out, model[a]);
    end

    // R2 processor strobe path and its gating by ce1_n
    select_on(); addr = 8'd20; adsp_n = 0; step(); adsp_n = 1;
    step();
    chk("R1 adsp load", dq_out, model[20]);
    addr = 8'd21; ce1_n = 1; adsp_n = 0; step(); adsp_n = 1; select_on();
    step();
    chk("R2 adsp ignored", dq_out, model[20]);
    chk("R2 still active", 18'(dq_oe), 18'd1);

    // R1 deselect blocks writes, R10 first-clock mask, R9 async gate
    ce2 = 0; load_c(8'd30);
    step();
    chk("R1 deselect oe", 18'(dq_oe), 18'd0);
    gw_n = 0; dq_in = 18'h3FFFF; step(); gw_n = 1;
    chk("R1 no drive when deselected", 18'(dq_oe), 18'd0);
    select_on(); oe_n = 0; load_c(8'd30);
    chk("R10 first clock masked", 18'(dq_oe), 18'd0);
    step();
    chk("R1 deselected write ignored", dq_out, model[30]);
    chk("R10 drive after mask", 18'(dq_oe), 18'd1);
    oe_n = 1; #1;
    chk("R9 oe high floats", 18'(dq_oe), 18'd0);
    oe_n = 0; #1;
    chk("R9 oe low drives", 18'(dq_oe), 18'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule